// File: doc/BRIEF.md
# I2C Slave with High-Speed Mode Entry

This block is the bus-facing front end of a small data-converter register interface on a two-wire serial bus. It samples SCL and SDA on the system clock through a synchroniser and finds START, repeated START and STOP conditions. It then takes in address and data bytes and answers each one by pulling SDA low through an open-drain output-enable during the ninth clock. Its own 7-bit address has six fixed upper bits, set by a parameter, and a least significant bit taken from an external strap pin.

A master code byte of the form 00001xxx, sent as the first byte after START, gets no acknowledge and moves the block into high-speed timing. A flag output reports this so that the surrounding logic can change its timing. A repeated START keeps the current mode and a STOP ends it. In a write transfer, each data byte goes to the configuration register when its top bit is clear, or to the setup register when its top bit is set. A setup byte can also restore the configuration register to its power-on value, or open a bounded stream of monitor-setup bytes that fill a buffer in arrival order.

Top module: `i2c_hs_slave`

## Requirements
- R1: The address byte is {addr[6:0], rw} with the MSB first, where addr = {ADDR_HI, addr_lsb_i} and ADDR_HI defaults to 6'b011010. A matching address is acknowledged whether rw is 0 or 1.
- R2: An address byte that does not match gets no acknowledge, and the data bytes that follow it in that transfer are neither acknowledged nor stored.
- R3: An address-position byte whose top five bits are 00001 (0x08 to 0x0F) gets no acknowledge. hs_mode_o goes to 1 once the ninth clock ends.
- R4: A repeated START leaves hs_mode_o unchanged, and a STOP clears it to 0.
- R5: In a write to this slave, a data byte with bit 7 = 0 is loaded into cfg_o and a data byte with bit 7 = 1 is loaded into setup_o. Both are acknowledged.
- R6: After reset, cfg_o is 0x01 and setup_o is 0x80. Writing a setup byte with bit 1 set also returns cfg_o to 0x01.
- R7: A setup byte with bit 0 set opens a monitor stream. The next data bytes, up to 13 of them, are acknowledged and stored in order: the k-th byte (k from 0) goes to mon_data_o[8k+7:8k]. These bytes do not change cfg_o or setup_o.
- R8: Data bytes after the 13th monitor byte get no acknowledge and change no output.
- R9: A STOP or repeated START closes the monitor stream. The next data bytes are routed by bit 7 again, and buffer slots that were not written keep their contents.
- R10: sda_oe_o changes only while the synchronised SCL is low, and after reset it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_lsb_i | input | 1 | Strap that sets address bit 0 |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| hs_mode_o | output | 1 | 1 while in high-speed timing mode |
| cfg_o | output | 8 | Configuration register |
| setup_o | output | 8 | Setup register |
| mon_data_o | output | 104 | Monitor-setup buffer, slot k at bits 8k+7:8k |

## Verification
A bus edge reaches the state machine two system clocks after it appears at the pad, and its effect shows on sda_oe_o, hs_mode_o or the register outputs one clock after that. So every result is due three to four clocks after the SCL edge or STOP/START that causes it. The bench drives the pins on falling clock edges and holds every SCL phase for five clocks, so the acknowledge bit is read in the middle of the high phase. The mode flag is read four clocks after the ninth clock, and register contents are read after the closing STOP, once all these latencies have passed. A sweep over all 128 addresses with both strap values, each followed by a data byte, checks acknowledge, mode and configuration against a model kept in the bench.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_ACK,
        PH_SKIP
    } phase_e;

    localparam logic [4:0] HS_CODE_TAG   = 5'b00001;
    localparam logic [7:0] CFG_POR       = 8'h01;
    localparam logic [7:0] SETUP_POR     = 8'h80;
    localparam int         SETUP_RST_BIT = 1;
    localparam int         SETUP_MON_BIT = 0;

    typedef struct packed {
        phase_e     ph;
        phase_e     after;
        logic [7:0] shreg;
        logic [3:0] bits;
        logic       oe;
        logic       hs;
        logic       hs_pend;
    } link_st_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    localparam int LINES = 2;
    localparam int DEPTH = STAGES + 1;

    // line 1 = SCL, line 0 = SDA; top bit of each chain is the previous sample
    logic [LINES-1:0][DEPTH-1:0] chain_d, chain_q;
    logic [LINES-1:0]            raw;
    logic [LINES-1:0]            cur, prv;

    assign raw = {scl_i, sda_i};

    always_comb begin
        for (int l = 0; l < LINES; l++) begin
            chain_d[l] = {chain_q[l][DEPTH-2:0], raw[l]};
            cur[l]     = chain_q[l][STAGES-1];
            prv[l]     = chain_q[l][STAGES];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign scl_o      = cur[1];
    assign sda_o      = cur[0];
    assign scl_rise_o = cur[1] & ~prv[1];
    assign scl_fall_o = ~cur[1] & prv[1];
    assign start_o    = cur[1] & prv[1] & prv[0] & ~cur[0];
    assign stop_o     = cur[1] & prv[1] & ~prv[0] & cur[0];

endmodule

// File: rtl/i2c_hs_link.sv
module i2c_hs_link
    import i2c_hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] addr7_i,
    input  logic       scl_s_i,
    input  logic       sda_s_i,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       accept_i,
    output logic       sda_oe_o,
    output logic       hs_mode_o,
    output logic       wr_stb_o,
    output logic [7:0] wr_byte_o
);
    link_st_t st_d, st_q;
    logic     wr_stb;

    always_comb begin
        st_d   = st_q;
        wr_stb = 1'b0;
        if (stop_i) begin
            st_d.ph      = PH_IDLE;
            st_d.oe      = 1'b0;
            st_d.hs      = 1'b0;
            st_d.hs_pend = 1'b0;
        end else if (start_i) begin
            st_d.ph      = PH_ADDR;
            st_d.bits    = 4'd0;
            st_d.oe      = 1'b0;
            st_d.hs_pend = 1'b0;
        end else begin
            case (st_q.ph)
                PH_ADDR, PH_DATA: begin
                    if (scl_rise_i && st_q.bits < 4'd8) begin
                        st_d.shreg = {st_q.shreg[6:0], sda_s_i};
                        st_d.bits  = st_q.bits + 4'd1;
                    end else if (scl_fall_i && st_q.bits == 4'd8) begin
                        st_d.ph = PH_ACK;
                        if (st_q.ph == PH_ADDR) begin
                            if (st_q.shreg[7:1] == addr7_i) begin
                                st_d.oe    = 1'b1;
                                st_d.after = st_q.shreg[0] ? PH_SKIP : PH_DATA;
                            end else if (st_q.shreg[7:3] == HS_CODE_TAG) begin
                                st_d.oe      = 1'b0;
                                st_d.hs_pend = 1'b1;
                                st_d.after   = PH_SKIP;
                            end else begin
                                st_d.oe    = 1'b0;
                                st_d.after = PH_SKIP;
                            end
                        end else begin
                            st_d.after = PH_DATA;
                            if (accept_i) begin
                                st_d.oe = 1'b1;
                                wr_stb  = 1'b1;
                            end else begin
                                st_d.oe = 1'b0;
                            end
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall_i) begin
                        st_d.oe   = 1'b0;
                        st_d.bits = 4'd0;
                        st_d.ph   = st_q.after;
                        if (st_q.hs_pend) begin
                            st_d.hs      = 1'b1;
                            st_d.hs_pend = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, after: PH_IDLE, shreg: 8'h00, bits: 4'd0,
                      oe: 1'b0, hs: 1'b0, hs_pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe_o  = st_q.oe;
    assign hs_mode_o = st_q.hs;
    assign wr_stb_o  = wr_stb;
    assign wr_byte_o = st_q.shreg;

    a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s_i);
    a_r4_stop_drops_hs: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !hs_mode_o);
    a_r4_rstart_keeps_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> $stable(hs_mode_o));
    a_r3_hs_entry_unacked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode_o) |-> !sda_oe_o);

endmodule

// File: rtl/i2c_hs_regs.sv
module i2c_hs_regs
    import i2c_hs_pkg::*;
#(
    parameter int NMON = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic [7:0]        wr_byte_i,
    input  logic              seq_end_i,
    output logic              accept_o,
    output logic [7:0]        cfg_o,
    output logic [7:0]        setup_o,
    output logic [NMON*8-1:0] mon_o
);
    localparam int            CW   = $clog2(NMON + 1);
    localparam logic [CW-1:0] FULL = CW'(NMON);

    typedef struct packed {
        logic [7:0]            cfg;
        logic [7:0]            setup;
        logic                  mon_on;
        logic [CW-1:0]         cnt;
        logic [NMON-1:0][7:0]  mon;
    } reg_st_t;

    reg_st_t rg_d, rg_q;

    always_comb begin
        rg_d     = rg_q;
        accept_o = !(rg_q.mon_on && rg_q.cnt == FULL);
        if (seq_end_i) begin
            rg_d.mon_on = 1'b0;
            rg_d.cnt    = '0;
        end else if (wr_stb_i) begin
            if (rg_q.mon_on) begin
                if (rg_q.cnt < FULL) begin
                    rg_d.mon[rg_q.cnt] = wr_byte_i;
                    rg_d.cnt           = rg_q.cnt + 1'b1;
                end
            end else if (wr_byte_i[7]) begin
                rg_d.setup = wr_byte_i;
                if (wr_byte_i[SETUP_RST_BIT]) rg_d.cfg = CFG_POR;
                if (wr_byte_i[SETUP_MON_BIT]) rg_d.mon_on = 1'b1;
            end else begin
                rg_d.cfg = wr_byte_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '{cfg: CFG_POR, setup: SETUP_POR, mon_on: 1'b0, cnt: '0, mon: '0};
        end else begin
            rg_q <= rg_d;
        end
    end

    assign cfg_o   = rg_q.cfg;
    assign setup_o = rg_q.setup;
    assign mon_o   = rg_q.mon;

    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.cnt <= FULL);
    a_r8_no_store_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_i |-> accept_o);
    a_r6_setup_resets_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && !seq_end_i && !rg_q.mon_on && wr_byte_i[7] && wr_byte_i[SETUP_RST_BIT])
        |=> cfg_o == CFG_POR);
    a_r7_stream_spares_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && !seq_end_i && rg_q.mon_on) |=> ($stable(cfg_o) && $stable(setup_o)));

endmodule

// File: rtl/i2c_hs_slave.sv
module i2c_hs_slave
    import i2c_hs_pkg::*;
#(
    parameter logic [5:0] ADDR_HI     = 6'b011010,
    parameter int         NMON        = 13,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_lsb_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic              hs_mode_o,
    output logic [7:0]        cfg_o,
    output logic [7:0]        setup_o,
    output logic [NMON*8-1:0] mon_data_o
);
    logic       scl_s, sda_s, start_evt, stop_evt, scl_rise, scl_fall;
    logic       accept, wr_stb;
    logic [7:0] wr_byte;
    logic [6:0] addr7;

    assign addr7 = {ADDR_HI, addr_lsb_i};

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .start_o    (start_evt),
        .stop_o     (stop_evt),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall)
    );

    i2c_hs_link u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr7_i    (addr7),
        .scl_s_i    (scl_s),
        .sda_s_i    (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_evt),
        .stop_i     (stop_evt),
        .accept_i   (accept),
        .sda_oe_o   (sda_oe_o),
        .hs_mode_o  (hs_mode_o),
        .wr_stb_o   (wr_stb),
        .wr_byte_o  (wr_byte)
    );

    i2c_hs_regs #(.NMON(NMON)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb_i  (wr_stb),
        .wr_byte_i (wr_byte),
        .seq_end_i (start_evt | stop_evt),
        .accept_o  (accept),
        .cfg_o     (cfg_o),
        .setup_o   (setup_o),
        .mon_o     (mon_data_o)
    );

endmodule

// File: tb/sim_i2c_hs_slave.sv
module sim_i2c_hs_slave;
    localparam int H    = 5;
    localparam int NMON = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, hs;
    logic sda_line;
    logic [7:0] cfg, setup;
    logic [NMON*8-1:0] mon;

    int vectors = 0;
    int miscompares = 0;
    int oe_viol = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_hs_slave u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_lsb_i (strap),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .hs_mode_o  (hs),
        .cfg_o      (cfg),
        .setup_o    (setup),
        .mon_data_o (mon)
    );

    // R10: bench-side watch that the pull-down never moves while SCL is high
    logic prev_scl = 1'b1, prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && prev_scl && (sda_oe !== prev_oe)) oe_viol++;
        prev_scl <= scl_m;
        prev_oe  <= sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; hold(H);
        sda_m = 1'b0; hold(H);
        scl_m = 1'b0; hold(H);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; hold(H);
        scl_m = 1'b1; hold(H);
        sda_m = 1'b0; hold(H);
        scl_m = 1'b0; hold(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(H);
        scl_m = 1'b1; hold(H);
        sda_m = 1'b1; hold(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(H);
            scl_m = 1'b1; hold(H);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; hold(H);
        scl_m = 1'b1; hold(2);
        acked = ~sda_line;
        hold(H - 2);
        scl_m = 1'b0;
    endtask

    function automatic logic [7:0] mon_val(input int k);
        return 8'((k * 37 + 5) & 8'hFF);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] exp_cfg;
        logic [6:0] own;
        logic [7:0] d;
        logic [NMON*8-1:0] exp_mon;

        hold(4);
        // R6 / R10: reset state
        chk("R6 cfg reset", 32'(cfg), 32'h01);
        chk("R6 setup reset", 32'(setup), 32'h80);
        chk("R4 hs reset", 32'(hs), 32'h0);
        chk("R10 oe reset", 32'(sda_oe), 32'h0);
        chk("R7 buffer reset", 32'(mon == '0), 32'h1);
        rst_n = 1'b1;
        hold(4);

        exp_cfg = 8'h01;
        // R1 R2 R3 R4: sweep every address with both strap values
        for (int s = 0; s < 2; s++) begin
            strap = s[0];
            hold(2);
            own = {6'b011010, strap};
            for (int a = 0; a < 128; a++) begin
                logic is_hs;
                logic match;
                is_hs = (a[6:2] == 5'b00001);
                match = (a[6:0] == own);
                d = {2'b01, a[5:0]};
                bus_start();
                send_byte({a[6:0], 1'b0}, ack);
                chk(match ? "R1 own address ack" : "R2 foreign address nack", 32'(ack), 32'(match));
                hold(4);
                chk("R3 hs flag after first byte", 32'(hs), 32'(is_hs));
                send_byte(d, ack);
                chk("R2 data ack only when addressed", 32'(ack), 32'(match));
                if (match) exp_cfg = d;
                bus_stop();
                hold(4);
                chk("R4 stop clears hs", 32'(hs), 32'h0);
                chk("R2 cfg after sweep byte", 32'(cfg), 32'(exp_cfg));
            end
        end

        strap = 1'b0;
        own = 7'b0110100;
        hold(2);

        // R1: read direction acknowledged
        bus_start();
        send_byte({own, 1'b1}, ack);
        chk("R1 read address ack", 32'(ack), 32'h1);
        bus_stop();

        // R5: routing by top bit
        bus_start();
        send_byte({own, 1'b0}, ack);
        send_byte(8'h1B, ack);
        chk("R5 cfg byte ack", 32'(ack), 32'h1);
        send_byte(8'h94, ack);
        chk("R5 setup byte ack", 32'(ack), 32'h1);
        bus_stop();
        hold(4);
        chk("R5 cfg loaded", 32'(cfg), 32'h1B);
        chk("R5 setup loaded", 32'(setup), 32'h94);

        // R6: setup with reset bit restores configuration
        bus_start();
        send_byte({own, 1'b0}, ack);
        send_byte(8'h86, ack);
        bus_stop();
        hold(4);
        chk("R6 cfg restored", 32'(cfg), 32'h01);
        chk("R6 setup written", 32'(setup), 32'h86);

        // R7 R8: full monitor stream plus one extra byte
        bus_start();
        send_byte({own, 1'b0}, ack);
        send_byte(8'h22, ack);
        send_byte(8'h81, ack);
        chk("R7 stream opener ack", 32'(ack), 32'h1);
        for (int k = 0; k < NMON; k++) begin
            send_byte(mon_val(k), ack);
            chk("R7 monitor byte ack", 32'(ack), 32'h1);
        end
        send_byte(8'h5A, ack);
        chk("R8 extra byte nack", 32'(ack), 32'h0);
        bus_stop();
        hold(4);
        exp_mon = '0;
        for (int k = 0; k < NMON; k++) exp_mon[8*k +: 8] = mon_val(k);
        for (int k = 0; k < NMON; k++)
            chk("R7 slot contents", 32'(mon[8*k +: 8]), 32'(exp_mon[8*k +: 8]));
        chk("R7 cfg untouched by stream", 32'(cfg), 32'h22);
        chk("R8 setup untouched", 32'(setup), 32'h81);

        // R9: repeated START closes the stream
        bus_start();
        send_byte({own, 1'b0}, ack);
        send_byte(8'h81, ack);
        send_byte(8'hA1, ack);
        send_byte(8'h52, ack);
        bus_rstart();
        send_byte({own, 1'b0}, ack);
        send_byte(8'h33, ack);
        chk("R9 byte after Sr ack", 32'(ack), 32'h1);
        bus_stop();
        hold(4);
        exp_mon[7:0]  = 8'hA1;
        exp_mon[15:8] = 8'h52;
        chk("R9 cfg routed after Sr", 32'(cfg), 32'h33);
        chk("R9 partial buffer", 32'(mon == exp_mon), 32'h1);

        // R9: STOP closes the stream
        bus_start();
        send_byte({own, 1'b0}, ack);
        send_byte(8'h81, ack);
        send_byte(8'hC4, ack);
        bus_stop();
        bus_start();
        send_byte({own, 1'b0}, ack);
        send_byte(8'h44, ack);
        bus_stop();
        hold(4);
        exp_mon[7:0] = 8'hC4;
        chk("R9 cfg routed after stop", 32'(cfg), 32'h44);
        chk("R9 buffer after stop", 32'(mon == exp_mon), 32'h1);

        // R3 R4: HS entry, transfer in HS, leave on STOP
        bus_start();
        send_byte(8'h0D, ack);
        chk("R3 master code nack", 32'(ack), 32'h0);
        hold(4);
        chk("R3 hs entered", 32'(hs), 32'h1);
        bus_rstart();
        chk("R4 Sr keeps hs", 32'(hs), 32'h1);
        send_byte({own, 1'b0}, ack);
        chk("R1 address ack in hs", 32'(ack), 32'h1);
        send_byte(8'h19, ack);
        chk("R5 data ack in hs", 32'(ack), 32'h1);
        chk("R4 hs held through transfer", 32'(hs), 32'h1);
        bus_stop();
        hold(4);
        chk("R4 stop leaves hs", 32'(hs), 32'h0);
        chk("R5 cfg written in hs", 32'(cfg), 32'h19);

        chk("R10 oe steady while SCL high", 32'(oe_viol), 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule